// File: doc/BRIEF.md
# Pulsed Overload Protection Controller

This block supervises one power output channel against overloads. An external comparator reports an overload on `ovl_det`. In dynamic mode the controller keeps the output supplied for a short window, and then alternates between a long shutdown and a fresh supply window until one full window passes with no overload. In static mode the external clamp limits the current, and this block only reports the condition. All timing counts a one-millisecond enable tick, `ms_tick`.

A sticky status bit, `ovl_stat`, and an active-low fault pin, `fault_n`, report the overload. The bit is cleared only by a status read made after the overload has gone. The channel's voltage-select field is held here and is written through `vsel_wr` and `vsel_wdata`. When latch recovery is selected, the end of an overload clears this field. The output then stays off until software writes the field again. The block has no streaming interface: every pin is plain control or status.

Top module: `ovl_guard`

## Requirements
- R1: In dynamic mode (`mode_static`=0), an overload sampled in normal operation keeps `out_en` high for an on-window of 90 ticks when `long_on`=0 or 180 ticks when `long_on`=1. At the clock edge of the last tick of the window, an overload that is still present drives `out_en` low.
- R2: The shutdown lasts 900 ticks. `out_en` then rises for a new on-window. If the overload is present at the last tick of that window, the block shuts down again.
- R3: Normal operation returns only when an on-window ends with no overload seen anywhere in it. If an overload is seen during a window but is absent at its last tick, a new window starts.
- R4: `ovl_stat` is 1 from the clock edge after `ovl_det` is sampled high. `fault_n` is its inverse at all times.
- R5: `ovl_stat` clears at a clock edge where `stat_rd`=1, `ovl_det`=0 and the channel is in normal operation. A read under any other condition leaves it at 1.
- R6: In static mode (`mode_static`=1), an overload never drives `out_en` low, and no retry cycle starts.
- R7: With `latch_rec`=1, the end of an overload clears `vsel_q` to 0, and so `out_en` goes low. The end of an overload is either a return to normal operation with `ovl_det`=0, or a fall of `ovl_det` during normal operation. Writing a nonzero `vsel_q` turns the output back on.
- R8: `vsel_wr`=1 loads `vsel_wdata` into `vsel_q` at the next edge. A load takes priority over a latch clear. `out_en` is low whenever `vsel_q` is 0.
- R9: The window counters advance only on edges where `ms_tick`=1. Without ticks, a window never ends.
- R10: A change of `mode_static` during a cycle acts at the next window end. With `mode_static`=1 at that point, the block returns to normal operation with `out_en` high.
- R11: A synchronous reset (`rst`=1) gives normal operation with `ovl_stat`=0, `fault_n`=1, `vsel_q`=0 and `out_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle enable per millisecond |
| ovl_det | input | 1 | Overload comparator output |
| mode_static | input | 1 | 1: static clamp, 0: pulsed retry |
| long_on | input | 1 | Selects the 180-tick on-window instead of 90 |
| latch_rec | input | 1 | Latch recovery: clear voltage select at overload end |
| stat_rd | input | 1 | Status register read strobe |
| vsel_wr | input | 1 | Voltage-select write strobe |
| vsel_wdata | input | VSEL_W | Voltage-select write data |
| vsel_q | output | VSEL_W | Current voltage-select field |
| out_en | output | 1 | Output stage enable |
| fault_n | output | 1 | Fault pin, active low |
| ovl_stat | output | 1 | Sticky overload status bit |

## Verification
Every result here is registered once. A status set or clear, a voltage-select load or clear, and a state change all appear one clock after the edge that samples their cause. The bench therefore drives inputs on a falling edge and checks on the next falling edge. For window timing, `out_en` changes at the edge carrying the Nth tick after entry, where N is 90, 180 or 900. The bench checks each boundary twice: one edge before, where the old value must still hold, and at the boundary edge itself. The read-clear rule is checked at the edge where the channel is still in a window and again at the first edge in normal operation.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ST_NORM  = 2'd0,
    ST_WATCH = 2'd1,
    ST_SHUT  = 2'd2
  } ovl_st_e;
endpackage

// File: rtl/ovl_timer.sv
module ovl_timer #(
  parameter int SHORT_MS = 90,
  parameter int LONG_MS  = 180,
  parameter int OFF_MS   = 900
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic sel_off,
  input  logic sel_long,
  output logic expire
);
  localparam int M1 = (SHORT_MS > LONG_MS) ? SHORT_MS : LONG_MS;
  localparam int MX = (M1 > OFF_MS) ? M1 : OFF_MS;
  localparam int CW = $clog2(MX + 1);
  localparam logic [CW-1:0] T_SHORT = CW'(SHORT_MS - 1);
  localparam logic [CW-1:0] T_LONG  = CW'(LONG_MS - 1);
  localparam logic [CW-1:0] T_OFF   = CW'(OFF_MS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    if (sel_off)       last = T_OFF;
    else if (sel_long) last = T_LONG;
    else               last = T_SHORT;
  end

  assign expire = run && tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ovl_seq.sv
module ovl_seq
  import ovl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ovl_det,
  input  logic    mode_static,
  input  logic    expire,
  output ovl_st_e st_q,
  output logic    restart,
  output logic    end_evt
);
  ovl_st_e st_d;
  logic    seen_q;
  logic    ovl_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORM:  if (!mode_static && ovl_det) st_d = ST_WATCH;
      ST_WATCH: if (expire) begin
                  if (mode_static)  st_d = ST_NORM;
                  else if (ovl_det) st_d = ST_SHUT;
                  else if (seen_q)  st_d = ST_WATCH;
                  else              st_d = ST_NORM;
                end
      ST_SHUT:  if (expire) st_d = mode_static ? ST_NORM : ST_WATCH;
      default:  st_d = ST_NORM;
    endcase
  end

  assign restart = expire || (st_q == ST_NORM && st_d != ST_NORM);
  assign end_evt = !ovl_det &&
                   ((st_q != ST_NORM && st_d == ST_NORM) ||
                    (st_q == ST_NORM && ovl_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_NORM;
      seen_q <= 1'b0;
      ovl_d  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovl_d <= ovl_det;
      if (st_q == ST_NORM)      seen_q <= ovl_det;
      else if (st_q == ST_SHUT) seen_q <= 1'b0;
      else if (expire)          seen_q <= 1'b0;
      else                      seen_q <= seen_q | ovl_det;
    end
  end
endmodule

// File: rtl/ovl_flag.sv
module ovl_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rd,
  input  logic quiet,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)                flag_q <= 1'b0;
    else if (set)           flag_q <= 1'b1;
    else if (rd && quiet)   flag_q <= 1'b0;
  end
endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
  import ovl_pkg::*;
#(
  parameter int VSEL_W   = 2,
  parameter int SHORT_MS = 90,
  parameter int LONG_MS  = 180,
  parameter int OFF_MS   = 900
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              ovl_det,
  input  logic              mode_static,
  input  logic              long_on,
  input  logic              latch_rec,
  input  logic              stat_rd,
  input  logic              vsel_wr,
  input  logic [VSEL_W-1:0] vsel_wdata,
  output logic [VSEL_W-1:0] vsel_q,
  output logic              out_en,
  output logic              fault_n,
  output logic              ovl_stat
);
  ovl_st_e st_q;
  logic    restart;
  logic    end_evt;
  logic    expire;

  ovl_seq u_seq (
    .clk(clk), .rst(rst), .ovl_det(ovl_det), .mode_static(mode_static),
    .expire(expire), .st_q(st_q), .restart(restart), .end_evt(end_evt)
  );

  ovl_timer #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS), .OFF_MS(OFF_MS)) u_tmr (
    .clk(clk), .rst(rst), .tick(ms_tick), .run(st_q != ST_NORM),
    .restart(restart), .sel_off(st_q == ST_SHUT), .sel_long(long_on),
    .expire(expire)
  );

  ovl_flag u_flag (
    .clk(clk), .rst(rst), .set(ovl_det), .rd(stat_rd),
    .quiet(!ovl_det && st_q == ST_NORM), .flag_q(ovl_stat)
  );

  always_ff @(posedge clk) begin
    if (rst)                       vsel_q <= '0;
    else if (vsel_wr)              vsel_q <= vsel_wdata;
    else if (latch_rec && end_evt) vsel_q <= '0;
  end

  assign out_en  = (|vsel_q) && (st_q != ST_SHUT);
  assign fault_n = !ovl_stat;
endmodule

// File: rtl/ovl_guard_chk.sv
module ovl_guard_chk
  import ovl_pkg::*;
#(
  parameter int VSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ms_tick,
  input logic              ovl_det,
  input logic              mode_static,
  input logic              stat_rd,
  input logic [VSEL_W-1:0] vsel_q,
  input logic              out_en,
  input logic              ovl_stat,
  input ovl_st_e           st_q
);
  // R4: detection sets the sticky bit one edge later
  a_r4_set_on_detect: assert property (@(posedge clk) disable iff (rst)
    ovl_det |=> ovl_stat);

  // R5: without a read the bit never drops
  a_r5_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    (ovl_stat && !stat_rd) |=> ovl_stat);

  // R5: no clear while a retry cycle is running
  a_r5_hold_in_cycle: assert property (@(posedge clk) disable iff (rst)
    (ovl_stat && st_q != ST_NORM) |=> ovl_stat);

  // R8: zero voltage select means the output is off
  a_r8_zero_vsel_off: assert property (@(posedge clk) disable iff (rst)
    (vsel_q == '0) |-> !out_en);

  // R6: static mode never leaves normal operation
  a_r6_static_stays: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORM && mode_static) |=> (st_q == ST_NORM));

  // R9: without a tick an active window cannot end
  a_r9_tick_gates: assert property (@(posedge clk) disable iff (rst)
    (!ms_tick && st_q != ST_NORM) |=> $stable(st_q));

  // R1: output drops with unchanged select only because of an overload
  a_r1_off_needs_overload: assert property (@(posedge clk) disable iff (rst)
    ($fell(out_en) && $stable(vsel_q)) |-> $past(ovl_det));
endmodule

bind ovl_guard ovl_guard_chk #(.VSEL_W(VSEL_W)) u_chk (
  .clk(clk), .rst(rst), .ms_tick(ms_tick), .ovl_det(ovl_det),
  .mode_static(mode_static), .stat_rd(stat_rd), .vsel_q(vsel_q),
  .out_en(out_en), .ovl_stat(ovl_stat), .st_q(st_q)
);

// File: tb/sim_ovl_guard.sv
`timescale 1ns/1ps
module sim_ovl_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b1;
  logic       ovl_det = 1'b0;
  logic       mode_static = 1'b0;
  logic       long_on = 1'b0;
  logic       latch_rec = 1'b0;
  logic       stat_rd = 1'b0;
  logic       vsel_wr = 1'b0;
  logic [1:0] vsel_wdata = 2'd0;
  logic [1:0] vsel_q;
  logic       out_en, fault_n, ovl_stat;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ovl_guard u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .ovl_det(ovl_det),
    .mode_static(mode_static), .long_on(long_on), .latch_rec(latch_rec),
    .stat_rd(stat_rd), .vsel_wr(vsel_wr), .vsel_wdata(vsel_wdata),
    .vsel_q(vsel_q), .out_en(out_en), .fault_n(fault_n), .ovl_stat(ovl_stat)
  );

  // static-mode vectors: {ovl, rd, wr, wdata[1:0], exp_en, exp_fault_n, exp_stat}
  localparam logic [7:0] TBL [11] = '{
    8'b0000_0110, 8'b1000_0101, 8'b1100_0101, 8'b0000_0101,
    8'b0100_0110, 8'b0000_0110, 8'b1000_0101, 8'b0100_0110,
    8'b0010_0010, 8'b1011_0101, 8'b0100_0110
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] v);
    rst = 1'b1; ovl_det = 1'b0; stat_rd = 1'b0; vsel_wr = 1'b0;
    mode_static = 1'b0; long_on = 1'b0; latch_rec = 1'b0; ms_tick = 1'b1;
    run(2);
    rst = 1'b0;
    vsel_wr = 1'b1; vsel_wdata = v;
    run(1);
    vsel_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11: reset state
    run(2);
    chk("R11 out_en", out_en, 0);
    chk("R11 fault_n", fault_n, 1);
    chk("R11 ovl_stat", ovl_stat, 0);
    chk("R11 vsel_q", vsel_q, 0);

    // table: static mode (R4 R5 R6 R8)
    do_reset(2'd1);
    mode_static = 1'b1;
    for (int i = 0; i < 11; i++) begin
      ovl_det = TBL[i][7]; stat_rd = TBL[i][6]; vsel_wr = TBL[i][5];
      vsel_wdata = TBL[i][4:3];
      run(1);
      chk("R6/R8 out_en", out_en, TBL[i][2]);
      chk("R4 fault_n", fault_n, TBL[i][1]);
      chk("R5 ovl_stat", ovl_stat, TBL[i][0]);
    end
    ovl_det = 1'b0; stat_rd = 1'b0; vsel_wr = 1'b0;

    // R1 R2 R3 R5: dynamic, short window, overload removed during shutdown
    do_reset(2'd1);
    ovl_det = 1'b1;
    run(1);
    chk("R1 en in window", out_en, 1);
    chk("R4 stat set", ovl_stat, 1);
    run(89);
    chk("R1 en at tick 89", out_en, 1);
    run(1);
    chk("R1 off at tick 90", out_en, 0);
    ovl_det = 1'b0;
    run(899);
    chk("R2 off at tick 899", out_en, 0);
    run(1);
    chk("R2 on at tick 900", out_en, 1);
    run(89);
    stat_rd = 1'b1;
    run(1);
    chk("R5 read in window ignored", ovl_stat, 1);
    run(1);
    chk("R3/R5 cleared in normal", ovl_stat, 0);
    chk("R3 en normal", out_en, 1);
    stat_rd = 1'b0;

    // R2: persistent overload repeats shutdown
    do_reset(2'd3);
    ovl_det = 1'b1;
    run(91);
    chk("R1 off", out_en, 0);
    run(900);
    chk("R2 retry on", out_en, 1);
    run(89);
    chk("R2 retry window tick 89", out_en, 1);
    run(1);
    chk("R2 off again", out_en, 0);

    // R1: long window
    do_reset(2'd1);
    long_on = 1'b1; ovl_det = 1'b1;
    run(180);
    chk("R1 long tick 179", out_en, 1);
    run(1);
    chk("R1 long off", out_en, 0);

    // R9: no ticks, no expiry
    do_reset(2'd1);
    ms_tick = 1'b0; ovl_det = 1'b1;
    run(400);
    chk("R9 held without tick", out_en, 1);
    ms_tick = 1'b1;
    run(89);
    chk("R9 tick 89", out_en, 1);
    run(1);
    chk("R9 off at tick 90", out_en, 0);

    // R10: switch to static during cycle, back to normal at expiry
    do_reset(2'd1);
    ovl_det = 1'b1;
    run(10);
    mode_static = 1'b1;
    run(81);
    chk("R10 normal at window end", out_en, 1);
    run(20);
    chk("R10 static holds on", out_en, 1);
    chk("R10 stat kept", ovl_stat, 1);

    // R7 R3: dynamic latch recovery, overload seen then gone -> window restart
    do_reset(2'd2);
    latch_rec = 1'b1; ovl_det = 1'b1;
    run(1);
    ovl_det = 1'b0;
    run(90);
    chk("R3 restart window en", out_en, 1);
    stat_rd = 1'b1;
    run(1);
    chk("R3 still in window, read ignored", ovl_stat, 1);
    stat_rd = 1'b0;
    run(88);
    chk("R7 before end vsel", vsel_q, 2);
    run(1);
    chk("R7 vsel cleared", vsel_q, 0);
    chk("R7 out off", out_en, 0);
    run(5);
    chk("R7 stays off", out_en, 0);
    vsel_wr = 1'b1; vsel_wdata = 2'd3;
    run(1);
    vsel_wr = 1'b0;
    chk("R7/R8 rewrite on", out_en, 1);

    // R7: static latch recovery on overload fall
    do_reset(2'd1);
    mode_static = 1'b1; latch_rec = 1'b1; ovl_det = 1'b1;
    run(3);
    chk("R6 static on", out_en, 1);
    ovl_det = 1'b0;
    run(1);
    chk("R7 static clear", vsel_q, 0);
    chk("R7 static off", out_en, 0);

    // R8: write beats latch clear
    do_reset(2'd1);
    mode_static = 1'b1; latch_rec = 1'b1; ovl_det = 1'b1;
    run(2);
    ovl_det = 1'b0; vsel_wr = 1'b1; vsel_wdata = 2'd2;
    run(1);
    vsel_wr = 1'b0;
    chk("R8 write priority", vsel_q, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule